// File: doc/BRIEF.md
# Burst-of-Two Dual-Port Synchronous SRAM

This block is a synchronous memory with a dedicated read port and a dedicated write port. Each port can accept one command per clock period, and both can accept one in the same period. Every operation moves two data beats over a data bus half as wide as the stored word. A write gathers its two beats, each with its own byte mask, into a pending register. It then commits the whole word to the array in one step. A read fetches one full word and returns its low half and then its high half on consecutive beats.

The two edges of the interface clock are modelled as two phases of a single synthesizable clock `clk`, which runs at twice the period rate. After reset the first edge is a phase-0 edge, and the edges then alternate between phase 0 and phase 1. A period is one phase-0 edge followed by one phase-1 edge.

Commands are sampled only on phase-0 edges. Write data and byte masks are sampled on both edges of the period that follows the write command. Read data appears two periods after the read command. A read always returns the data written by every write command accepted in an earlier period, whether or not that write has reached the array.

Top module: `bo2_sram`

## Requirements
- R1: A read command and a write command may both be accepted on the same phase-0 edge, each with its own address.
- R2: `rd_en`, `rd_addr`, `wr_en` and `wr_addr` are sampled only on phase-0 edges. Their values at phase-1 edges have no effect on the array or on `q_valid`.
- R3: The write address is taken with the write command. The low half of the word (bits DW-1:0) is taken from `wd` at the next phase-0 edge, and the high half (bits 2*DW-1:DW) at the phase-1 edge that follows. The word is committed only after both halves are held. `wd` and `wbe` outside these two slots have no effect.
- R4: `wbe` is sampled with each data beat. Bit k enables byte k (bits 8k+7:8k) of that beat. A byte whose enable is 0 keeps its previous contents, and a beat with an all-zero mask changes nothing.
- R5: A read accepted at a phase-0 edge raises `q_valid` after the phase-0 edge two periods later. `q` then shows the low half of the word. After the next phase-1 edge `q` shows the high half. `q_valid` stays high for exactly those two beats unless another read follows.
- R6: A read accepted in a period after a write command to the same address returns the new bytes, merged per byte under the masks, even if the write is still pending.
- R7: A read and a write to the same address accepted on the same edge return the word as it was before that write.
- R8: Reset clears `q_valid`, the read pipeline and any pending write. A write not yet committed is dropped. The array contents are kept.
- R9: The address is AW bits wide and selects one of 2**AW words of two beats each. The whole range, including the highest address, is usable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; its edges alternate phase 0 and phase 1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read command, sampled on phase-0 edges |
| rd_addr | input | AW | Read word address |
| wr_en | input | 1 | Write command, sampled on phase-0 edges |
| wr_addr | input | AW | Write word address |
| wd | input | DW | Write data beat |
| wbe | input | DW/8 | Byte enables for the current write beat |
| q | output | DW | Read data beat |
| q_valid | output | 1 | High while `q` carries a read beat |

## Verification
A wrong pending-write state has two visible effects. A stale forward shows up in the first read beat two periods after an overlapping read. A lost or doubled commit shows up in the first later read of that address, even when that read comes many periods afterwards. A phase slip or a command sampled on the wrong edge moves `q_valid` by one beat, or raises it with no read behind it. Either fault shows at once in the beat-by-beat valid comparison. The stimulus places active command and data values on every unused edge, so any leakage through the ignored slots turns into a data miscompare on a later read.

// File: rtl/bo2_sram.sv
module bo2_sram #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wd,
  input  logic [DW/8-1:0] wbe,
  output logic [DW-1:0] q,
  output logic          q_valid
);
  localparam int NB    = DW / 8;
  localparam int WW    = 2 * DW;
  localparam int WB    = 2 * NB;
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  logic          ph;
  logic          wcmd, phalf, pfull;
  logic          rcmd, rword_v, qv;
  logic [AW-1:0] wa, pa, ra;
  logic [WW-1:0] pd, rword, fwd_word;
  logic [WB-1:0] pm;
  logic [DW-1:0] qd, qhi;
  logic          hit;

  assign hit     = pfull && (pa == ra);
  assign q       = qd;
  assign q_valid = qv;

  for (genvar b = 0; b < WB; b++) begin : g_fwd
    assign fwd_word[8*b +: 8] = (hit && pm[b]) ? pd[8*b +: 8] : mem[ra][8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= 1'b0;
      wcmd    <= 1'b0;
      phalf   <= 1'b0;
      pfull   <= 1'b0;
      rcmd    <= 1'b0;
      rword_v <= 1'b0;
      qv      <= 1'b0;
    end else begin
      ph <= ~ph;
      if (!ph) begin
        wcmd    <= wr_en;
        rcmd    <= rd_en;
        phalf   <= wcmd;
        pfull   <= 1'b0;
        rword_v <= rcmd;
        qv      <= rword_v;
      end else begin
        phalf <= 1'b0;
        if (phalf) pfull <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!ph) begin
      if (rd_en) ra <= rd_addr;
      if (wr_en) wa <= wr_addr;
      if (wcmd) begin
        pa         <= wa;
        pd[DW-1:0] <= wd;
        pm[NB-1:0] <= wbe;
      end
      if (rcmd) rword <= fwd_word;
      qd  <= rword[DW-1:0];
      qhi <= rword[WW-1:DW];
    end else begin
      if (phalf) begin
        pd[WW-1:DW] <= wd;
        pm[WB-1:NB] <= wbe;
      end
      qd <= qhi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !ph && pfull) begin
      for (int b = 0; b < WB; b++) begin
        if (pm[b]) mem[pa][8*b +: 8] <= pd[8*b +: 8];
      end
    end
  end
endmodule

module bo2_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_en,
  input logic ph,
  input logic pfull,
  input logic q_valid
);
  p_reset_idle_r8: assert property (@(posedge clk) !rst_n |=> !q_valid);

  p_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !ph) |-> ##5 q_valid);

  p_beat0_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_valid) |-> ph);

  p_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && ph) |=> q_valid);

  p_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_valid) |-> $past(rd_en && !ph, 5));

  p_retire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pfull |=> !pfull);

  p_full_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pfull) |-> !ph);
endmodule

bind bo2_sram bo2_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .ph(ph), .pfull(pfull), .q_valid(q_valid)
);

// File: tb/sim_bo2_sram.sv
module sim_bo2_sram;
  localparam int NV = 18;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_en, wr_en;
  logic [3:0]  rd_addr, wr_addr;
  logic [15:0] wd;
  logic [1:0]  wbe;
  logic [15:0] q;
  logic        q_valid;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bo2_sram #(.AW(4), .DW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wd(wd), .wbe(wbe),
    .q(q), .q_valid(q_valid)
  );

  // {rd, ra, wr, wa, beat0, mask0, beat1, mask1}
  localparam logic [45:0] VEC [NV] = '{
    {1'b0,4'd0, 1'b1,4'd3,  16'h1111,2'b11,16'h2222,2'b11},
    {1'b1,4'd3, 1'b1,4'd5,  16'hAAAA,2'b11,16'hBBBB,2'b11}, // R1 R6
    {1'b1,4'd5, 1'b1,4'd5,  16'hCCCC,2'b01,16'hDDDD,2'b10}, // R7 R4
    {1'b1,4'd5, 1'b0,4'd0,  16'h0000,2'b00,16'h0000,2'b00}, // R6 masked forward
    {1'b0,4'd0, 1'b1,4'd15, 16'h7777,2'b11,16'h8888,2'b11}, // R9
    {1'b1,4'd5, 1'b0,4'd0,  16'h0000,2'b00,16'h0000,2'b00},
    {1'b1,4'd3, 1'b1,4'd7,  16'h1234,2'b11,16'h5678,2'b11},
    {1'b1,4'd7, 1'b1,4'd7,  16'hFFFF,2'b00,16'hFFFF,2'b00}, // R4 empty mask
    {1'b1,4'd7, 1'b0,4'd0,  16'h0000,2'b00,16'h0000,2'b00},
    {1'b1,4'd15,1'b1,4'd0,  16'h0F0F,2'b11,16'hF0F0,2'b11},
    {1'b1,4'd0, 1'b1,4'd0,  16'h9999,2'b10,16'h8888,2'b01},
    {1'b1,4'd0, 1'b1,4'd3,  16'hABCD,2'b11,16'hEF01,2'b11},
    {1'b1,4'd3, 1'b0,4'd0,  16'h0000,2'b00,16'h0000,2'b00},
    {1'b1,4'd0, 1'b0,4'd0,  16'h0000,2'b00,16'h0000,2'b00},
    {1'b1,4'd15,1'b1,4'd15, 16'hAA55,2'b01,16'h55AA,2'b10}, // R7 R9
    {1'b1,4'd15,1'b0,4'd0,  16'h0000,2'b00,16'h0000,2'b00},
    {1'b0,4'd0, 1'b0,4'd0,  16'h0000,2'b00,16'h0000,2'b00},
    {1'b0,4'd0, 1'b0,4'd0,  16'h0000,2'b00,16'h0000,2'b00}
  };

  logic [31:0] mdl   [16];
  logic [31:0] expw  [NV];
  logic        exprd [NV];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_beat(input int k, input bit hi);
    logic ev;
    ev = (k >= 0 && k < NV) ? exprd[k] : 1'b0;
    chk($sformatf("R2 R5 valid, vector %0d beat %0d", k, hi), {31'd0, q_valid}, {31'd0, ev});
    if (ev)
      chk($sformatf("R3 R4 R6 R7 R9 data, vector %0d beat %0d", k, hi), {16'd0, q},
          {16'd0, hi ? expw[k][31:16] : expw[k][15:0]});
  endtask

  task automatic drive_period(input logic r, input logic [3:0] ra_, input logic w,
                              input logic [3:0] wa_, input logic [15:0] da,
                              input logic [1:0] ma, input logic [15:0] db,
                              input logic [1:0] mb);
    rd_en = r; rd_addr = ra_; wr_en = w; wr_addr = wa_; wd = da; wbe = ma;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; wd = db; wbe = mb;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R5 watchdog expired: got 0 expected 1 (run end)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    rd_addr = '0; wr_addr = '0; wd = '0; wbe = '0;
    repeat (3) @(negedge clk);
    chk("R8 reset state", {31'd0, q_valid}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV + 3; i++) begin
      logic [45:0] v, pv;
      v  = (i < NV) ? VEC[i] : '0;
      pv = (i >= 1 && i - 1 < NV) ? VEC[i-1] : '0;
      check_beat(i - 3, 1'b1);
      rd_en = v[45]; rd_addr = v[44:41]; wr_en = v[40]; wr_addr = v[39:36];
      wd  = pv[40] ? pv[35:20] : (16'hDEAD ^ 16'(i));
      wbe = pv[40] ? pv[19:18] : 2'b11;
      if (i < NV) begin
        exprd[i] = v[45];
        expw[i]  = v[45] ? mdl[v[44:41]] : '0;
        if (v[40]) begin
          if (v[18]) mdl[v[39:36]][7:0]   = v[27:20];
          if (v[19]) mdl[v[39:36]][15:8]  = v[35:28];
          if (v[0])  mdl[v[39:36]][23:16] = v[9:2];
          if (v[1])  mdl[v[39:36]][31:24] = v[17:10];
        end
      end
      @(negedge clk);
      check_beat(i - 2, 1'b0);
      rd_en = 1'b1; rd_addr = ~4'(i); wr_en = 1'b1; wr_addr = 4'(i);
      wd  = pv[40] ? pv[17:2] : (16'hBEEF ^ 16'(i));
      wbe = pv[40] ? pv[1:0] : 2'b11;
      @(negedge clk);
    end

    // R8: pending write dropped by reset, array kept
    drive_period(1'b0, 4'd0, 1'b1, 4'd9, 16'h0, 2'b00, 16'h0, 2'b00);
    drive_period(1'b0, 4'd0, 1'b0, 4'd0, 16'h1357, 2'b11, 16'h2468, 2'b11);
    drive_period(1'b1, 4'd9, 1'b1, 4'd9, 16'h0, 2'b00, 16'h0, 2'b00);
    drive_period(1'b0, 4'd0, 1'b0, 4'd0, 16'h0000, 2'b11, 16'hFFFF, 2'b11);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 valid cleared by reset", {31'd0, q_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive_period(1'b1, 4'd9, 1'b0, 4'd0, 16'h0, 2'b00, 16'h0, 2'b00);
    drive_period(1'b0, 4'd0, 1'b0, 4'd0, 16'h0, 2'b00, 16'h0, 2'b00);
    chk("R8 no beat from flushed read", {31'd0, q_valid}, 32'd0);
    @(negedge clk);
    chk("R5 valid on first beat", {31'd0, q_valid}, 32'd1);
    chk("R8 array kept, low beat", {16'd0, q}, 32'h1357);
    @(negedge clk);
    chk("R5 valid on second beat", {31'd0, q_valid}, 32'd1);
    chk("R8 array kept, high beat", {16'd0, q}, 32'h2468);
    @(negedge clk);
    chk("R5 valid drops after two beats", {31'd0, q_valid}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule